// File: doc/BRIEF.md
# Dual-width ROM read port

This block is a synthesizable behavioural model of the device side of a parallel read-only memory. The memory is organised as 16-bit words and can be read either 16 bits at a time or 8 bits at a time. A strap input picks the width. In byte mode one extra low-order select line chooses which half of the stored word appears on the low data lane. On the physical part that select line shares a pin with the top data bit. Here it is modelled as its own input `byteSel`, which is ignored in word mode.

The port decodes its operating mode from an active-low chip enable, an active-low output enable, the width strap, a flag that says the programming supply is present, and a high-voltage identify flag. It then drives stored data, a fixed identifier code or nothing. High impedance is expressed per 8-bit lane through `laneOe`; a lane that is not driven carries zeros. The stored array is a small table computed from parameters. Every result is registered and appears a fixed number of clocks after its inputs are sampled; this latency stands in for access time.

Top module: `dual_width_rom`

## Requirements
- R1: While reset is asserted, and until the first sampled request has passed the pipeline, `dataOut` is 0 and `laneOe` is 2'b00.
- R2: With `ceN` high and `progActive` low, no lane is driven, whatever `oeN` is.
- R3: With `ceN` low and `oeN` high, no lane is driven.
- R4: Word read: with `ceN`=0, `oeN`=0, `progActive`=0, `wideMode`=1 and `idHv`=0, `laneOe`=2'b11 and `dataOut` is the full stored word at `addr`; `byteSel` has no effect.
- R5: Byte read: with `ceN`=0, `oeN`=0, `progActive`=0 and `wideMode`=0, `laneOe`=2'b01. `dataOut[7:0]` is bits 7..0 of the stored word when `byteSel`=0, and bits 15..8 when `byteSel`=1. `idHv` has no effect in this mode.
- R6: Identify: with `ceN`=0, `oeN`=0, `progActive`=0, `wideMode`=1 and `idHv`=1, `laneOe`=2'b01. `dataOut[7:0]` is 8'h20 when `addr[0]`=0 and 8'hB1 when `addr[0]`=1.
- R7: The stored word at address i, for i below PROG_WORDS (default 48), is {i[7:0] XOR 8'h5A, i[7:0]}. Every other address, including any at or above DEPTH, reads 16'hFFFF (erased).
- R8: A request sampled on a rising clock edge shows on the outputs after exactly LATENCY rising edges (default 2), counting that edge as the first.
- R9: Verify: with `progActive`=1, `ceN`=1 and `oeN`=0, `laneOe`=2'b11 and `dataOut` is the full stored word, whatever `wideMode` is.
- R10: With `progActive`=1 and `ceN`=0, no lane is driven, whatever `oeN` is.
- R11: Bits of a lane whose `laneOe` bit is 0 read 0. The upper lane is never driven without the lower lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (20) | Word address |
| byteSel | input | 1 | Half-word select in byte mode (0 = bits 7..0, 1 = bits 15..8) |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| wideMode | input | 1 | Width strap: 1 = 16-bit, 0 = 8-bit |
| progActive | input | 1 | Programming supply present |
| idHv | input | 1 | High-voltage identify request |
| dataOut | output | 16 | Read data; an undriven lane reads 0 |
| laneOe | output | 2 | Lane enables: bit 0 for bits 7..0, bit 1 for bits 15..8 |

## Verification
Word reads walk every array address and some far addresses, with `byteSel` toggling underneath. This separates programmed words, erased words and the out-of-depth fallback, and shows the select is ignored in word mode. Byte reads use both select values at the same addresses, so a lane swap or a wrong half is caught. Identify with address bit 0 at both values and identify under byte mode tell the code path apart from a normal read. Long runs of `$urandom` control mixes, compared on every clock against a reference model, separate the standby, disable, verify and program-pulse float cases from each other and pin down the latency at every transition.

// File: rtl/rom_pkg.sv
package rom_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned BUS_W  = LANE_W * LANES;

  localparam logic [LANE_W-1:0] MFR_CODE  = 8'h20;
  localparam logic [LANE_W-1:0] DEV_CODE  = 8'hB1;
  localparam logic [LANE_W-1:0] FILL_MASK = 8'h5A;

  typedef enum logic [2:0] {
    MODE_FLOAT,
    MODE_WORD,
    MODE_BYTE,
    MODE_IDENT,
    MODE_VERIFY
  } rdMode_t;

  // Strobes from the mode decoder to the datapath
  typedef struct packed {
    logic driveLo;
    logic driveHi;
    logic pickIdent;
    logic pickUpper;
  } rdStrobe_t;
endpackage

// File: rtl/rom_mode_ctrl.sv
module rom_mode_ctrl
  import rom_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      oeN,
  input  logic      wideMode,
  input  logic      progActive,
  input  logic      idHv,
  input  logic      byteSel,
  output rdStrobe_t strb
);
  rdMode_t mode;

  // Mode decode. Chip enable has the highest priority, then output enable,
  // then the programming supply, then identify.
  always_comb begin
    mode = MODE_FLOAT;
    if (ceN) begin
      if (progActive && !oeN) mode = MODE_VERIFY;
    end else if (!oeN && !progActive) begin
      if (wideMode && idHv)  mode = MODE_IDENT;
      else if (wideMode)     mode = MODE_WORD;
      else                   mode = MODE_BYTE;
    end
  end

  always_comb begin
    strb = '0;
    unique case (mode)
      MODE_WORD, MODE_VERIFY: begin
        strb.driveLo = 1'b1;
        strb.driveHi = 1'b1;
      end
      MODE_BYTE: begin
        strb.driveLo   = 1'b1;
        strb.pickUpper = byteSel;
      end
      MODE_IDENT: begin
        strb.driveLo   = 1'b1;
        strb.pickIdent = 1'b1;
      end
      default: ;
    endcase
  end

  // R2
  standby_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceN && !progActive) |-> (!strb.driveLo && !strb.driveHi));

  // R3
  out_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeN) |-> (!strb.driveLo && !strb.driveHi));

  // R5
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && !progActive && !wideMode) |-> (strb.driveLo && !strb.driveHi && !strb.pickIdent));

  // R10
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && progActive) |-> (!strb.driveLo && !strb.driveHi));
endmodule

// File: rtl/rom_datapath.sv
module rom_datapath
  import rom_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned PROG_WORDS = 48,
  parameter int unsigned LATENCY    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  rdStrobe_t         strb,
  output logic [BUS_W-1:0]  dataOut,
  output logic [LANES-1:0]  laneOe
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] PROG_A  = ADDR_W'(PROG_WORDS);

  // Computed content table
  logic [BUS_W-1:0] romArr [DEPTH];
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [LANE_W-1:0] LOW = LANE_W'(g);
    if (g < PROG_WORDS) begin : g_prog
      assign romArr[g] = {LOW ^ FILL_MASK, LOW};
    end else begin : g_blank
      assign romArr[g] = '1;
    end
  end

  logic              inRange;
  logic [BUS_W-1:0]  storedWord;
  logic [LANE_W-1:0] loByte;
  logic [LANE_W-1:0] laneByte [LANES];
  logic [BUS_W-1:0]  nxtData;
  logic [LANES-1:0]  nxtOe;

  assign inRange    = addr < DEPTH_A;
  assign storedWord = inRange ? romArr[addr[IDX_W-1:0]] : '1;

  always_comb begin
    if (strb.pickIdent)      loByte = addr[0] ? DEV_CODE : MFR_CODE;
    else if (strb.pickUpper) loByte = storedWord[BUS_W-1 -: LANE_W];
    else                     loByte = storedWord[LANE_W-1:0];
  end

  assign laneByte[0] = loByte;
  assign laneByte[1] = storedWord[BUS_W-1 -: LANE_W];
  assign nxtOe       = {strb.driveHi, strb.driveLo};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign nxtData[l*LANE_W +: LANE_W] = nxtOe[l] ? laneByte[l] : '0;
  end

  // Access pipeline
  logic [BUS_W-1:0] stData [LATENCY];
  logic [LANES-1:0] stOe   [LATENCY];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < LATENCY; s++) begin
        stData[s] <= '0;
        stOe[s]   <= '0;
      end
    end else begin
      stData[0] <= nxtData;
      stOe[0]   <= nxtOe;
      for (int s = 1; s < LATENCY; s++) begin
        stData[s] <= stData[s-1];
        stOe[s]   <= stOe[s-1];
      end
    end
  end

  assign dataOut = stData[LATENCY-1];
  assign laneOe  = stOe[LATENCY-1];

  // R6
  ident_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pickIdent |=> (stData[0][LANE_W-1:0] == MFR_CODE || stData[0][LANE_W-1:0] == DEV_CODE));

  // R7
  erased_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.driveHi && addr >= PROG_A) |=> (stData[0][BUS_W-1 -: LANE_W] == '1));

  // R11
  float_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((laneOe[0] || dataOut[LANE_W-1:0] == '0) && (laneOe[1] || dataOut[BUS_W-1 -: LANE_W] == '0)));

  // R11
  lane_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneOe[1] |-> laneOe[0]);
endmodule

// File: rtl/dual_width_rom.sv
module dual_width_rom
  import rom_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned PROG_WORDS = 48,
  parameter int unsigned LATENCY    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byteSel,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              wideMode,
  input  logic              progActive,
  input  logic              idHv,
  output logic [BUS_W-1:0]  dataOut,
  output logic [LANES-1:0]  laneOe
);
  rdStrobe_t strb;

  rom_mode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .wideMode(wideMode),
    .progActive(progActive), .idHv(idHv), .byteSel(byteSel), .strb(strb)
  );

  rom_datapath #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .PROG_WORDS(PROG_WORDS), .LATENCY(LATENCY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .strb(strb),
    .dataOut(dataOut), .laneOe(laneOe)
  );
endmodule

// File: tb/tb_dual_width_rom.sv
`timescale 1ns/1ps
module tb_dual_width_rom;
  localparam int LAT = 2;

  typedef struct packed {
    logic [15:0] d;
    logic [1:0]  oe;
    logic [7:0]  req;
  } expRec_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] addr = '0;
  logic        byteSel = 1'b0, ceN = 1'b1, oeN = 1'b1, wideMode = 1'b1;
  logic        progActive = 1'b0, idHv = 1'b0;
  logic [15:0] dataOut;
  logic [1:0]  laneOe;

  int  checks = 0;
  int  fails  = 0;
  bit  running = 0;
  bit  done = 0;
  expRec_t q[$];

  always #2 clk = ~clk;

  dual_width_rom #(.LATENCY(LAT)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .byteSel(byteSel), .ceN(ceN), .oeN(oeN),
    .wideMode(wideMode), .progActive(progActive), .idHv(idHv),
    .dataOut(dataOut), .laneOe(laneOe)
  );

  // R7: stored content
  function automatic logic [15:0] memWord(input logic [19:0] a);
    if (a < 20'd48) return {a[7:0] ^ 8'h5A, a[7:0]};
    return 16'hFFFF;
  endfunction

  function automatic expRec_t model();
    expRec_t r;
    r.d = '0; r.oe = 2'b00;
    if (ceN) begin
      if (progActive && !oeN) begin r.d = memWord(addr); r.oe = 2'b11; r.req = 9; end // R9
      else r.req = 2; // R2
    end else if (oeN) r.req = 3;                   // R3
    else if (progActive) r.req = 10;               // R10
    else if (idHv && wideMode) begin               // R6
      r.d = {8'h00, addr[0] ? 8'hB1 : 8'h20}; r.oe = 2'b01; r.req = 6;
    end else if (wideMode) begin                   // R4 / R7
      r.d = memWord(addr); r.oe = 2'b11; r.req = (addr >= 20'd48) ? 7 : 4;
    end else begin                                 // R5
      r.d = {8'h00, byteSel ? memWord(addr)[15:8] : memWord(addr)[7:0]}; r.oe = 2'b01; r.req = 5;
    end
    return r;
  endfunction

  // Per-cycle comparison; alignment with the queue also checks R8 timing, and
  // zeroed undriven lanes cover R11
  always @(negedge clk) begin
    if (running) begin
      q.push_back(model());
      if (q.size() == LAT + 1) begin
        expRec_t e;
        e = q.pop_front();
        checks++;
        if (dataOut !== e.d || laneOe !== e.oe) begin
          fails++;
          $display("FAIL R%0d (R8/R11 alignment): actual data=%h oe=%b expected data=%h oe=%b",
                   e.req, dataOut, laneOe, e.d, e.oe);
        end
      end
    end
  end

  task automatic drive(input logic [19:0] a, input logic bs, input logic ce, input logic oe,
                       input logic w, input logic p, input logic i);
    @(posedge clk); #1;
    addr = a; byteSel = bs; ceN = ce; oeN = oe; wideMode = w; progActive = p; idHv = i;
  endtask

  initial begin
    // R1: reset state
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (dataOut !== 16'h0 || laneOe !== 2'b00) begin
        fails++;
        $display("FAIL R1: actual data=%h oe=%b expected data=0000 oe=00", dataOut, laneOe);
      end
    end
    @(posedge clk); #1; rstN = 1'b1; running = 1;

    // R4 / R7: every array word, select toggling underneath
    for (int a = 0; a < 64; a++) drive(20'(a), a[1], 0, 0, 1, 0, 0);
    drive(20'hFFFFF, 1, 0, 0, 1, 0, 0);
    drive(20'h00100, 0, 0, 0, 1, 0, 0);
    drive(20'd47, 1, 0, 0, 1, 0, 0);
    drive(20'd48, 0, 0, 0, 1, 0, 0);
    // R5: both halves
    for (int a = 0; a < 24; a++) begin
      drive(20'(a), 0, 0, 0, 0, 0, 0);
      drive(20'(a), 1, 0, 0, 0, 0, 0);
    end
    drive(20'd60, 1, 0, 0, 0, 0, 1);     // R5: identify ignored in byte mode
    // R6: identify codes
    drive(20'd0, 0, 0, 0, 1, 0, 1);
    drive(20'd1, 0, 0, 0, 1, 0, 1);
    drive(20'd0, 1, 0, 0, 1, 0, 1);
    drive(20'd1, 0, 0, 1, 1, 0, 1);      // R3 with identify
    // R2: standby
    drive(20'd5, 0, 1, 0, 1, 0, 0);
    drive(20'd5, 0, 1, 1, 0, 0, 1);
    // R3: output disable
    drive(20'd7, 0, 0, 1, 1, 0, 0);
    drive(20'd9, 0, 0, 0, 1, 0, 0);      // R8: float to driven edge
    drive(20'd9, 0, 0, 1, 1, 0, 0);      // R8: driven to float edge
    // R9: verify in either width
    drive(20'd12, 0, 1, 0, 1, 1, 0);
    drive(20'd12, 0, 1, 0, 0, 1, 0);
    drive(20'd50, 1, 1, 0, 0, 1, 0);
    // R10: program pulse floats
    drive(20'd12, 0, 0, 0, 1, 1, 0);
    drive(20'd12, 0, 0, 1, 0, 1, 1);
    // Mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[31] ? 20'($urandom) : 20'(r[6:0]), r[8], r[9] & r[10], r[11] & r[12],
            r[13], r[14] & r[15], r[16]);
    end
    drive(20'd0, 0, 1, 1, 1, 0, 0);
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule